// File: doc/BRIEF.md
# Linear Sub-Window Copy Address Engine

This engine turns a fixed-length copy command into a stream of address pairs. A producer writes thirteen 32-bit words through a valid/ready command port. The words describe a three-dimensional box of elements to be moved from one linear surface to another. Each surface has its own base address, starting corner, row pitch and slice pitch, and both share one element size.

Once the final word is in, the engine checks the command. If the command is sound, the engine walks the box and offers one read address and one write address per handshake on the request port. A downstream data mover consumes those pairs. After the last pair it pulses `done`. If the command is malformed, the engine discards it, pulses `err` and issues no requests at all.

Top module: `subwin_copy_engine`

## Requirements
- R1: A command is 13 words, in this order: header, source base low, source base high, source corner x/y, source corner z with row pitch, source slice pitch, destination base low, destination base high, destination corner x/y, destination corner z with row pitch, destination slice pitch, width/height, depth. The header is accepted when bits 7:0 equal 0x01 and bits 15:8 equal 0x04. Header bits 31:29 hold the log2 of the element size in bytes, with legal values 0 to 4.
- R2: Field positions are as follows. In a corner x/y word, x is in bits 13:0 and y is in bits 29:16. In a corner z/pitch word, z is in bits 10:0 and (row pitch − 1) is in bits 31:13. A slice-pitch word holds (slice pitch − 1) in bits 27:0. Pitches are counted in elements.
- R3: The byte address of box element (i,j,k) on a surface is base + ((z0+k)·slice + (y0+j)·pitch + (x0+i)) · element size. Each surface uses its own base, corner and pitches.
- R4: Elements are visited with i fastest, then j, then k. Exactly one read/write pair is consumed per cycle in which `req_valid` and `req_ready` are both high.
- R5: The width/height word holds (width − 1) in bits 13:0 and (height − 1) in bits 29:16. The depth word holds (depth − 1) in bits 10:0. The engine issues exactly width·height·depth pairs.
- R6: A header whose opcode byte or sub-opcode byte differs from R1 makes the engine drop the command. `err` then pulses for one cycle, the cycle after the last word, and no request is issued.
- R7: A source or destination base with either of its two low bits set causes the command to be dropped, as in R6.
- R8: The command is dropped, as in R6, in two further cases. One is an element-size code above 4. The other is a row pitch of either surface that is not a multiple of 4/size when the element size is 1 or 2 bytes.
- R9: `cmd_ready` is low from the cycle after the last word of a valid command up to and including the cycle of the final request handshake.
- R10: `done` is high for exactly the one cycle that follows the final request handshake.
- R11: While `req_valid` is high and `req_ready` is low, `req_valid` and both addresses hold their values into the next cycle.
- R12: During and after reset, `cmd_ready` is 1 and `req_valid`, `done` and `err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command word offered |
| cmd_data | input | 32 | Command word |
| cmd_ready | output | 1 | Engine takes the word this cycle |
| req_valid | output | 1 | Address pair offered |
| req_ready | input | 1 | Downstream takes the pair |
| req_rd_addr | output | ADDR_W | Source byte address |
| req_wr_addr | output | ADDR_W | Destination byte address |
| done | output | 1 | Copy finished (one cycle) |
| err | output | 1 | Command dropped (one cycle) |

## Verification
Any wrong internal state reaches the request port within the same handshake. A misdecoded field or a stale stored word shows up as a wrong first address in the cycle after launch. A counter that wraps at the wrong limit shows up either as an address jump within the row where it happens, or as a wrong pair count when `done` arrives. A broken validation path appears one cycle after the last word: `err` is missing, or requests appear where none should. The stall checks show, at the next cycle, whether a hold under backpressure slipped.

// File: rtl/scw_pkg.sv
package scw_pkg;
  localparam int PKT_WORDS = 13;
  localparam int CNT_W     = 4;
  localparam int XY_W      = 14;
  localparam int Z_W       = 11;
  localparam int PITCH_W   = 20;
  localparam int SLICE_W   = 29;
  localparam logic [7:0] OP_COPY   = 8'h01;
  localparam logic [7:0] SUB_LINWIN = 8'h04;

  typedef struct packed {
    logic [63:0]        base;
    logic [XY_W-1:0]    x0;
    logic [XY_W-1:0]    y0;
    logic [Z_W-1:0]     z0;
    logic [PITCH_W-1:0] pitch;
    logic [SLICE_W-1:0] slice;
  } surf_t;

  function automatic surf_t unpack_surf(input logic [31:0] lo, input logic [31:0] hi,
                                        input logic [31:0] xy, input logic [31:0] zp,
                                        input logic [31:0] sl);
    surf_t s;
    s.base  = {hi, lo};
    s.x0    = xy[13:0];
    s.y0    = xy[29:16];
    s.z0    = zp[10:0];
    s.pitch = {1'b0, zp[31:13]} + 20'd1;
    s.slice = {1'b0, sl[27:0]} + 29'd1;
    return s;
  endfunction

  function automatic logic pitch_fits(input logic [2:0] lg, input logic [PITCH_W-1:0] p);
    case (lg)
      3'd0:    return p[1:0] == 2'b00;
      3'd1:    return p[0] == 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [63:0] elem_addr(input surf_t s, input logic [2:0] lg,
                                            input logic [XY_W-1:0] ci,
                                            input logic [XY_W-1:0] cj,
                                            input logic [Z_W-1:0] ck);
    logic [63:0] row, plane, col, idx;
    plane = 64'(s.z0 + 12'(ck)) * 64'(s.slice);
    row   = 64'(s.y0 + 15'(cj)) * 64'(s.pitch);
    col   = 64'(s.x0 + 15'(ci));
    idx   = plane + row + col;
    return s.base + (idx << lg);
  endfunction
endpackage

// File: rtl/scw_cmd_decoder.sv
module scw_cmd_decoder
  import scw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [31:0]       cmd_data,
  input  logic              busy,
  output logic              cmd_ready,
  output logic              launch_ok,
  output logic              launch_bad,
  output surf_t             src,
  output surf_t             dst,
  output logic [2:0]        lg,
  output logic [XY_W-1:0]   w_m1,
  output logic [XY_W-1:0]   h_m1,
  output logic [Z_W-1:0]    d_m1
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(PKT_WORDS - 1);

  logic [31:0]      wq [PKT_WORDS];
  logic [CNT_W-1:0] cnt;
  logic             take, take_last, hdr_ok, align_ok, sound;

  assign cmd_ready = !busy && !launch_ok;
  assign take      = cmd_valid && cmd_ready;
  assign take_last = take && (cnt == LAST_IDX);

  assign src  = unpack_surf(wq[1], wq[2], wq[3], wq[4], wq[5]);
  assign dst  = unpack_surf(wq[6], wq[7], wq[8], wq[9], wq[10]);
  assign lg   = wq[0][31:29];
  assign w_m1 = wq[11][13:0];
  assign h_m1 = wq[11][29:16];
  assign d_m1 = wq[12][10:0];

  assign hdr_ok   = (wq[0][7:0] == OP_COPY) && (wq[0][15:8] == SUB_LINWIN) && (lg <= 3'd4);
  assign align_ok = (wq[1][1:0] == 2'b00) && (wq[6][1:0] == 2'b00) &&
                    pitch_fits(lg, src.pitch) && pitch_fits(lg, dst.pitch);
  assign sound    = hdr_ok && align_ok;

  always_ff @(posedge clk) begin
    if (take) wq[cnt] <= cmd_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '0;
      launch_ok  <= 1'b0;
      launch_bad <= 1'b0;
    end else begin
      launch_ok  <= take_last && sound;
      launch_bad <= take_last && !sound;
      if (take) cnt <= take_last ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/scw_walker.sv
module scw_walker
  import scw_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic [XY_W-1:0] w_m1,
  input  logic [XY_W-1:0] h_m1,
  input  logic [Z_W-1:0]  d_m1,
  input  logic            req_ready,
  output logic            active,
  output logic [XY_W-1:0] ci,
  output logic [XY_W-1:0] cj,
  output logic [Z_W-1:0]  ck,
  output logic            step,
  output logic            final_step,
  output logic            done
);
  logic end_i, end_j, end_k;

  assign end_i      = (ci == w_m1);
  assign end_j      = (cj == h_m1);
  assign end_k      = (ck == d_m1);
  assign step       = active && req_ready;
  assign final_step = step && end_i && end_j && end_k;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      done   <= 1'b0;
      ci     <= '0;
      cj     <= '0;
      ck     <= '0;
    end else begin
      done <= final_step;
      if (go) begin
        active <= 1'b1;
        ci     <= '0;
        cj     <= '0;
        ck     <= '0;
      end else if (step) begin
        if (final_step) active <= 1'b0;
        if (!end_i) ci <= ci + 1'b1;
        else begin
          ci <= '0;
          if (!end_j) cj <= cj + 1'b1;
          else begin
            cj <= '0;
            ck <= ck + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/subwin_copy_engine.sv
module subwin_copy_engine
  import scw_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [31:0]       cmd_data,
  output logic              cmd_ready,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_rd_addr,
  output logic [ADDR_W-1:0] req_wr_addr,
  output logic              done,
  output logic              err
);
  surf_t           src_s, dst_s;
  logic [2:0]      lg;
  logic [XY_W-1:0] w_m1, h_m1, ci, cj;
  logic [Z_W-1:0]  d_m1, ck;
  logic            pkt_go, pkt_drop, walk_active, elem_hs, final_hs;

  scw_cmd_decoder u_dec (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .busy(walk_active), .cmd_ready(cmd_ready), .launch_ok(pkt_go),
    .launch_bad(pkt_drop), .src(src_s), .dst(dst_s), .lg(lg),
    .w_m1(w_m1), .h_m1(h_m1), .d_m1(d_m1)
  );

  scw_walker u_walk (
    .clk(clk), .rst_n(rst_n), .go(pkt_go), .w_m1(w_m1), .h_m1(h_m1),
    .d_m1(d_m1), .req_ready(req_ready), .active(walk_active), .ci(ci),
    .cj(cj), .ck(ck), .step(elem_hs), .final_step(final_hs), .done(done)
  );

  assign req_valid   = walk_active;
  assign err         = pkt_drop;
  assign req_rd_addr = ADDR_W'(elem_addr(src_s, lg, ci, cj, ck));
  assign req_wr_addr = ADDR_W'(elem_addr(dst_s, lg, ci, cj, ck));
endmodule

// File: rtl/scw_checks.sv
module scw_checks #(
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ready,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_rd_addr,
  input logic [ADDR_W-1:0] req_wr_addr,
  input logic              done,
  input logic              err,
  input logic              pkt_go,
  input logic              final_hs
);
  p_ready_off_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !cmd_ready);
  p_go_blocks_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_go |-> !cmd_ready);
  p_walk_starts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_go |=> req_valid);
  p_done_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    final_hs |=> done);
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_hold_under_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_rd_addr) && $stable(req_wr_addr)));
  p_drop_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!req_valid && !done));
  p_drop_stays_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !req_valid);
endmodule

bind subwin_copy_engine scw_checks #(.ADDR_W(ADDR_W)) u_scw_checks (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .req_valid(req_valid),
  .req_ready(req_ready), .req_rd_addr(req_rd_addr), .req_wr_addr(req_wr_addr),
  .done(done), .err(err), .pkt_go(pkt_go), .final_hs(final_hs)
);

// File: tb/test_subwin_copy_engine.sv
module test_subwin_copy_engine;
  localparam int ADDR_W = 64;
  localparam int NV = 3;
  localparam logic [31:0] VEC [NV][13] = '{
    '{32'h0000_0401, 32'h0000_1000, 32'h0, 32'h0002_0001, 32'h0000_E000, 32'd63,
      32'h0000_2000, 32'h0, 32'h0000_0003, 32'h0001_E001, 32'd127, 32'h0001_0002, 32'd1},
    '{32'h4000_0401, 32'h0001_0000, 32'h1, 32'h0001_0000, 32'h0000_8002, 32'd19,
      32'h0000_0100, 32'h0, 32'h0003_0002, 32'h0000_C000, 32'd49, 32'h0002_0001, 32'd0},
    '{32'h8000_0401, 32'h0000_0040, 32'h0, 32'h0000_0000, 32'h0000_4000, 32'd8,
      32'h8000_0000, 32'h0, 32'h0001_0001, 32'h0000_6001, 32'd15, 32'h0, 32'd2}
  };

  logic clk = 0, rst_n = 0, cmd_valid = 0, req_ready = 0;
  logic [31:0] cmd_data = 0;
  logic cmd_ready, req_valid, done, err;
  logic [ADDR_W-1:0] req_rd_addr, req_wr_addr;
  int errors = 0, checks = 0, cycles = 0;
  logic [31:0] cur [13];

  always #10 clk = ~clk;

  subwin_copy_engine #(.ADDR_W(ADDR_W)) i_subwin_copy_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .cmd_ready(cmd_ready), .req_valid(req_valid), .req_ready(req_ready),
    .req_rd_addr(req_rd_addr), .req_wr_addr(req_wr_addr), .done(done), .err(err)
  );

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<20000", cycles);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic send_cur();
    for (int w = 0; w < 13; w++) begin
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      cmd_valid = 1; cmd_data = cur[w];
      @(posedge clk);
    end
    @(negedge clk);
    cmd_valid = 0;
  endtask

  // Expected address per R2/R3, computed with multiplication.
  function automatic longint exp_addr(input logic [31:0] lo, input logic [31:0] hi,
      input logic [31:0] xy, input logic [31:0] zp, input logic [31:0] sl,
      input int i, input int j, input int k, input int esz);
    longint b, x, y, z, p, s;
    b = {hi, lo}; x = xy & 32'h3FFF; y = (xy >> 16) & 32'h3FFF;
    z = zp & 32'h7FF; p = (zp >> 13) + 1; s = (sl & 32'h0FFF_FFFF) + 1;
    return b + ((z + k) * s + (y + j) * p + (x + i)) * esz;
  endfunction

  // Runs a valid command; mode 1 toggles req_ready to stall.
  task automatic run_good(input int mode, input string tag);
    int w, h, d, esz, seen;
    logic tog, hold;
    logic [ADDR_W-1:0] hr, hw;
    esz = 1 << cur[0][31:29];
    w = (cur[11] & 32'h3FFF) + 1; h = ((cur[11] >> 16) & 32'h3FFF) + 1; d = (cur[12] & 32'h7FF) + 1;
    send_cur();
    // now in the cycle after the last word
    chk(!cmd_ready && !req_valid && !err, {tag, " R9 ready low after last word"}, cmd_ready, 0);
    tog = 0; hold = 0; seen = 0; hr = 0; hw = 0;
    for (int k = 0; k < d; k++)
      for (int j = 0; j < h; j++)
        for (int i = 0; i < w; i++) begin
          logic got;
          got = 0;
          while (!got) begin
            @(negedge clk);
            if (hold) begin
              chk(req_valid && req_rd_addr == hr && req_wr_addr == hw,
                  {tag, " R11 hold under stall"}, req_rd_addr, hr);
              hold = 0;
            end
            req_ready = (mode == 0) ? 1'b1 : tog;
            tog = ~tog;
            if (req_valid && req_ready) got = 1;
            else if (req_valid) begin hold = 1; hr = req_rd_addr; hw = req_wr_addr; end
          end
          chk(!cmd_ready, {tag, " R9 ready low while walking"}, cmd_ready, 0);
          chk(req_rd_addr == ADDR_W'(exp_addr(cur[1], cur[2], cur[3], cur[4], cur[5], i, j, k, esz)),
              {tag, " R3 R4 read address"}, req_rd_addr,
              exp_addr(cur[1], cur[2], cur[3], cur[4], cur[5], i, j, k, esz));
          chk(req_wr_addr == ADDR_W'(exp_addr(cur[6], cur[7], cur[8], cur[9], cur[10], i, j, k, esz)),
              {tag, " R2 R3 write address"}, req_wr_addr,
              exp_addr(cur[6], cur[7], cur[8], cur[9], cur[10], i, j, k, esz));
          seen++;
        end
    @(negedge clk);
    req_ready = 0;
    chk(done == 1'b1, {tag, " R10 done after final pair"}, done, 1);
    chk(!req_valid, {tag, " R5 no pair beyond count"}, seen, w * h * d);
    chk(cmd_ready, {tag, " R9 ready back"}, cmd_ready, 1);
    @(negedge clk);
    chk(!done, {tag, " R10 done single cycle"}, done, 0);
  endtask

  task automatic run_bad(input string tag);
    send_cur();
    chk(err == 1'b1, {tag, " err pulse"}, err, 1);
    chk(!req_valid, {tag, " no request"}, req_valid, 0);
    req_ready = 1;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      if (req_valid || done || err || !cmd_ready)
        chk(0, {tag, " stays quiet"}, {req_valid, done, err, cmd_ready}, 4'b0001);
    end
    chk(!req_valid && cmd_ready, {tag, " idle after drop"}, req_valid, 0);
    req_ready = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cmd_ready && !req_valid && !done && !err, "R12 state in reset", cmd_ready, 1);
    rst_n = 1;
    @(negedge clk);
    chk(cmd_ready && !req_valid && !done && !err, "R12 state after reset", req_valid, 0);

    // table of valid commands (R1 R2 R3 R4 R5)
    for (int v = 0; v < NV; v++) begin
      for (int w = 0; w < 13; w++) cur[w] = VEC[v][w];
      run_good(0, $sformatf("R1 vec%0d", v));
    end

    // backpressure on a 4-byte command
    for (int w = 0; w < 13; w++) cur[w] = VEC[1][w];
    run_good(1, "R11 stall vec1");

    // wrong opcode byte
    for (int w = 0; w < 13; w++) cur[w] = VEC[0][w];
    cur[0] = 32'h0000_0402;
    run_bad("R6 bad opcode");
    // wrong sub-opcode byte
    cur[0] = 32'h0000_0501;
    run_bad("R6 bad subop");
    // misaligned source and destination bases
    for (int w = 0; w < 13; w++) cur[w] = VEC[1][w];
    cur[1] = 32'h0001_0002;
    run_bad("R7 src misaligned");
    for (int w = 0; w < 13; w++) cur[w] = VEC[1][w];
    cur[6] = 32'h0000_0101;
    run_bad("R7 dst misaligned");
    // byte elements with row pitch 6 (not a multiple of 4)
    for (int w = 0; w < 13; w++) cur[w] = VEC[0][w];
    cur[4] = 32'h0000_A000;
    run_bad("R8 pitch align");
    // element size code 5
    for (int w = 0; w < 13; w++) cur[w] = VEC[1][w];
    cur[0] = 32'hA000_0401;
    run_bad("R8 size code");

    // engine still works after drops
    for (int w = 0; w < 13; w++) cur[w] = VEC[2][w];
    run_good(0, "R4 after drops");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule